// File: doc/BRIEF.md
# Host Attention Interrupt Controller

This block keeps the two-bit interrupt mask for a block-transfer style host messaging port and drives one level-sensitive interrupt line toward the host. The register decoder sends it mask-register writes. The message engine sends it a pulse each time a response is ready. The event-message logic sends it requests to raise or drop the event-message attention bit. The block also reads the current response-attention and event-message-attention status bits, which are kept elsewhere. From all of these it decides when the interrupt becomes pending and when it is cleared.

The mask has two fields at fixed positions, because the host driver decodes them. Bit 0 is the interrupt enable and bit 1 is the pending flag. The interrupt line is a copy of the pending flag. The host acknowledges an interrupt by writing 1 to the pending bit.

Inside a cycle the events are applied in a fixed order: the mask write first, then the response event, then the event-message request. A cold-reset pulse overrides all of them.

Top module: `bt_atn_irq_ctl`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, the mask reads 2'b00 and `irq_o` is 0.
- R2: `irq_o` always equals mask bit 1 (pending). Every mask change is visible on `mask_q` and `irq_o` right after the rising edge that captures its cause.
- R3: A write that changes bit 0 from 0 to 1 sets the enable. It also sets pending if `b2h_atn` or `sms_atn` is 1 at that time. If both are 0, only the enable is set.
- R4: A write whose bit 0 equals the stored enable leaves the enable unchanged and sets no pending, even when an attention bit is set.
- R5: A write that changes bit 0 from 1 to 0 clears both the enable and pending.
- R6: Writing 1 to bit 1 clears pending if pending is set, and has no effect if it is clear. The acknowledge is applied after the enable change of the same write, so writing 2'b11 to mask 2'b00 while an attention bit is set gives 2'b01.
- R7: A `rsp_ready` pulse sets pending only when `line_in_use`, `glob_irq_en` and the enable are all 1.
- R8: A `sms_set_req` while `sms_atn` is 0 sets pending only when `sms_irq_ok`, `line_in_use`, `glob_irq_en` and the enable are 1 and `b2h_atn` is 0. A set request while `sms_atn` is already 1 is ignored.
- R9: A `sms_clr_req` while `sms_atn` is 1 clears pending only when `b2h_atn` is 0. A clear request while `sms_atn` is 0 is ignored.
- R10: A `cold_rst` pulse clears both mask bits and overrides every other event in the same cycle.
- R11: Within one cycle, the response and event-message events see the enable as already updated by that cycle's mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 2 | Mask write data (bit 1 acknowledge, bit 0 enable) |
| rsp_ready | input | 1 | Response-ready event pulse |
| sms_set_req | input | 1 | Request to raise event-message attention |
| sms_clr_req | input | 1 | Request to drop event-message attention |
| sms_irq_ok | input | 1 | Set request may raise the interrupt |
| line_in_use | input | 1 | Interrupt line is wired up |
| glob_irq_en | input | 1 | Global interrupt enable |
| cold_rst | input | 1 | Cold-reset pulse |
| b2h_atn | input | 1 | Current response-attention status bit |
| sms_atn | input | 1 | Current event-message attention status bit |
| mask_q | output | 2 | Mask register (bit 1 pending, bit 0 enable) |
| irq_o | output | 1 | Level interrupt toward the host |

## Verification
Every result is due at the first rising edge after its cause, because there is exactly one register between any input and both outputs. The bench changes inputs on the falling edge and holds them for one full cycle. It samples `mask_q` and `irq_o` at the next falling edge, half a cycle after the capturing edge. Gating and ignore cases are checked by reading the mask in that same cycle, before the next stimulus is applied.

// File: rtl/bt_atn_irq_pkg.sv
// Package: shared mask layout for the host attention interrupt controller.
// Assumes the host decodes enable at bit 0 and pending at bit 1.
package bt_atn_irq_pkg;
    localparam int MASK_W = 2;
    localparam int EN_BIT = 0;
    localparam int PND_BIT = 1;

    // Packed order puts pnd at bit 1 and en at bit 0.
    typedef struct packed {
        logic pnd;
        logic en;
    } mask_t;

    // Qualified events, gated by everything except the enable bit.
    typedef struct packed {
        logic atn_any;
        logic rsp_ok;
        logic sms_up;
        logic sms_down;
    } evt_t;
endpackage

// File: rtl/bt_atn_evt_qual.sv
// Qualifies the raw event inputs against the global gates and the
// attention status bits. It leaves out the mask enable, because that
// depends on the write applied in the same cycle.
// Assumes the request inputs are one-cycle pulses.
module bt_atn_evt_qual
    import bt_atn_irq_pkg::*;
(
    input  logic rsp_ready,
    input  logic sms_set_req,
    input  logic sms_clr_req,
    input  logic sms_irq_ok,
    input  logic line_in_use,
    input  logic glob_irq_en,
    input  logic b2h_atn,
    input  logic sms_atn,
    output evt_t evt
);
    logic gate_open;

    // Purpose: the line is usable only when wired and globally enabled.
    always_comb gate_open = line_in_use & glob_irq_en;

    // Purpose: build the qualified event strobes.
    always_comb begin
        evt.atn_any  = b2h_atn | sms_atn;
        evt.rsp_ok   = rsp_ready & gate_open;
        evt.sms_up   = sms_set_req & ~sms_atn & sms_irq_ok & gate_open & ~b2h_atn;
        evt.sms_down = sms_clr_req & sms_atn & ~b2h_atn;
    end
endmodule

// File: rtl/bt_atn_mask_next.sv
// Computes the next mask value from the current one. The order is:
// mask write (enable change, then acknowledge), response event,
// event-message event, and last the cold reset, which overrides all.
// Purely combinational.
module bt_atn_mask_next
    import bt_atn_irq_pkg::*;
(
    input  mask_t cur,
    input  logic  wr_en,
    input  mask_t wr_data,
    input  evt_t  evt,
    input  logic  cold_rst,
    output mask_t nxt
);
    // Purpose: apply the events one after another in their fixed order.
    always_comb begin
        nxt = cur;
        if (wr_en) begin
            if (wr_data.en != nxt.en) begin
                if (wr_data.en) begin
                    if (evt.atn_any) nxt.pnd = 1'b1;
                    nxt.en = 1'b1;
                end else begin
                    nxt.pnd = 1'b0;
                    nxt.en  = 1'b0;
                end
            end
            if (wr_data.pnd && nxt.pnd) nxt.pnd = 1'b0;
        end
        if (evt.rsp_ok && nxt.en) nxt.pnd = 1'b1;
        if (evt.sms_up && nxt.en) nxt.pnd = 1'b1;
        if (evt.sms_down) nxt.pnd = 1'b0;
        if (cold_rst) nxt = '0;
    end
endmodule

// File: rtl/bt_atn_mask_reg.sv
// Holds the mask and drives the interrupt line from the registered
// pending bit, so the line never glitches.
// Assumes a synchronous active-low reset.
module bt_atn_mask_reg
    import bt_atn_irq_pkg::*;
#(
    parameter logic [MASK_W-1:0] POR_VALUE = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mask_t nxt,
    output mask_t q,
    output logic  irq
);
    // Purpose: capture the next mask on each clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= mask_t'(POR_VALUE);
        else        q <= nxt;
    end

    // Purpose: the interrupt level is the pending flag.
    always_comb irq = q.pnd;
endmodule

// File: rtl/bt_atn_irq_ctl.sv
// Top level of the host attention interrupt controller. Wires together
// the event qualifier, the next-state logic and the mask register.
// Assumes the attention status bits are kept by the register block.
module bt_atn_irq_ctl
    import bt_atn_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr_en,
    input  logic [MASK_W-1:0] mask_wr_data,
    input  logic              rsp_ready,
    input  logic              sms_set_req,
    input  logic              sms_clr_req,
    input  logic              sms_irq_ok,
    input  logic              line_in_use,
    input  logic              glob_irq_en,
    input  logic              cold_rst,
    input  logic              b2h_atn,
    input  logic              sms_atn,
    output logic [MASK_W-1:0] mask_q,
    output logic              irq_o
);
    evt_t  evt;
    mask_t cur;
    mask_t nxt;

    bt_atn_evt_qual u_qual (
        .rsp_ready   (rsp_ready),
        .sms_set_req (sms_set_req),
        .sms_clr_req (sms_clr_req),
        .sms_irq_ok  (sms_irq_ok),
        .line_in_use (line_in_use),
        .glob_irq_en (glob_irq_en),
        .b2h_atn     (b2h_atn),
        .sms_atn     (sms_atn),
        .evt         (evt)
    );

    bt_atn_mask_next u_next (
        .cur      (cur),
        .wr_en    (mask_wr_en),
        .wr_data  (mask_t'(mask_wr_data)),
        .evt      (evt),
        .cold_rst (cold_rst),
        .nxt      (nxt)
    );

    bt_atn_mask_reg #(.POR_VALUE('0)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .q     (cur),
        .irq   (irq_o)
    );

    // Purpose: bring the mask out as a plain vector.
    always_comb mask_q = cur;
endmodule

// File: rtl/bt_atn_irq_chk.sv
// Checker for the host attention interrupt controller, bound to the top.
module bt_atn_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mask_wr_en,
    input logic [1:0] mask_wr_data,
    input logic       rsp_ready,
    input logic       sms_set_req,
    input logic       sms_clr_req,
    input logic       glob_irq_en,
    input logic       cold_rst,
    input logic       b2h_atn,
    input logic [1:0] mask_q,
    input logic       irq_o
);
    AST_LINE_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == mask_q[1]); // R2
    AST_PND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[1] |-> mask_q[0]); // R3
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_en && !cold_rst |=> $stable(mask_q[0])); // R4
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en && !mask_wr_data[0] && mask_q[0] |=> !mask_q[1]); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en && mask_wr_data[1] && mask_q[1] && !rsp_ready && !sms_set_req
        |=> !mask_q[1]); // R6
    AST_RSP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready && !glob_irq_en && !mask_wr_en && !sms_set_req && !sms_clr_req && !cold_rst
        |=> $stable(mask_q)); // R7
    AST_SMS_CLR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sms_clr_req && b2h_atn && !mask_wr_en && !rsp_ready && !sms_set_req && !cold_rst
        |=> $stable(mask_q)); // R9
    AST_COLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst |=> mask_q == 2'b00); // R10
endmodule

bind bt_atn_irq_ctl bt_atn_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .rsp_ready    (rsp_ready),
    .sms_set_req  (sms_set_req),
    .sms_clr_req  (sms_clr_req),
    .glob_irq_en  (glob_irq_en),
    .cold_rst     (cold_rst),
    .b2h_atn      (b2h_atn),
    .mask_q       (mask_q),
    .irq_o        (irq_o)
);

// File: tb/sim_bt_atn_irq_ctl.sv
`timescale 1ns/1ps
module sim_bt_atn_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_wr_en = 1'b0;
    logic [1:0] mask_wr_data = 2'b00;
    logic       rsp_ready = 1'b0;
    logic       sms_set_req = 1'b0;
    logic       sms_clr_req = 1'b0;
    logic       sms_irq_ok = 1'b0;
    logic       line_in_use = 1'b1;
    logic       glob_irq_en = 1'b1;
    logic       cold_rst = 1'b0;
    logic       b2h_atn = 1'b0;
    logic       sms_atn = 1'b0;
    logic [1:0] mask_q;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bt_atn_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .rsp_ready(rsp_ready), .sms_set_req(sms_set_req), .sms_clr_req(sms_clr_req),
        .sms_irq_ok(sms_irq_ok), .line_in_use(line_in_use), .glob_irq_en(glob_irq_en),
        .cold_rst(cold_rst), .b2h_atn(b2h_atn), .sms_atn(sms_atn),
        .mask_q(mask_q), .irq_o(irq_o)
    );

    // Compare the mask, and the line against the expected pending bit.
    task automatic chk(input string req, input logic [1:0] exp);
        n_chk++;
        if (mask_q !== exp || irq_o !== exp[1]) begin
            n_fail++;
            $display("FAIL %s: mask=%b irq=%b expected mask=%b irq=%b", req, mask_q, irq_o, exp, exp[1]);
        end
    endtask

    // Let one capturing edge pass, then drop the strobes at the falling edge.
    task automatic tick();
        @(negedge clk);
        mask_wr_en = 0; rsp_ready = 0; sms_set_req = 0; sms_clr_req = 0; cold_rst = 0;
    endtask

    task automatic wr(input logic [1:0] d);
        mask_wr_en = 1; mask_wr_data = d; tick();
    endtask

    task automatic cold();
        cold_rst = 1; tick();
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R1", 2'b00);
        rst_n = 1; tick();
        chk("R1", 2'b00);
    endtask

    task automatic t_enable();
        b2h_atn = 1; wr(2'b01); chk("R3", 2'b11);
        chk("R2", 2'b11);
        cold(); b2h_atn = 0; sms_atn = 1; wr(2'b01); chk("R3", 2'b11);
        cold(); sms_atn = 0; wr(2'b01); chk("R3", 2'b01);
    endtask

    task automatic t_same_en();
        b2h_atn = 1; wr(2'b01); chk("R4", 2'b01);
        cold(); wr(2'b01); chk("R4", 2'b11);
        wr(2'b01); chk("R4", 2'b11);
        b2h_atn = 0;
    endtask

    task automatic t_ack();
        wr(2'b11); chk("R6", 2'b01);
        wr(2'b11); chk("R6", 2'b01);
        cold(); b2h_atn = 1; wr(2'b11); chk("R6", 2'b01);
        b2h_atn = 0;
    endtask

    task automatic t_disable();
        cold(); b2h_atn = 1; wr(2'b01); b2h_atn = 0;
        wr(2'b00); chk("R5", 2'b00);
    endtask

    task automatic t_rsp();
        cold(); wr(2'b01);
        rsp_ready = 1; tick(); chk("R7", 2'b11);
        wr(2'b11);
        glob_irq_en = 0; rsp_ready = 1; tick(); chk("R7", 2'b01);
        glob_irq_en = 1; line_in_use = 0; rsp_ready = 1; tick(); chk("R7", 2'b01);
        line_in_use = 1; cold(); rsp_ready = 1; tick(); chk("R7", 2'b00);
    endtask

    task automatic t_sms_set();
        cold(); wr(2'b01);
        sms_irq_ok = 1; sms_set_req = 1; tick(); chk("R8", 2'b11);
        wr(2'b11);
        sms_atn = 1; sms_set_req = 1; tick(); chk("R8", 2'b01);
        sms_atn = 0; sms_irq_ok = 0; sms_set_req = 1; tick(); chk("R8", 2'b01);
        sms_irq_ok = 1; b2h_atn = 1; sms_set_req = 1; tick(); chk("R8", 2'b01);
        b2h_atn = 0; sms_irq_ok = 0;
    endtask

    task automatic t_sms_clr();
        cold(); wr(2'b01); rsp_ready = 1; tick();
        sms_atn = 1; sms_clr_req = 1; tick(); chk("R9", 2'b01);
        rsp_ready = 1; tick();
        b2h_atn = 1; sms_clr_req = 1; tick(); chk("R9", 2'b11);
        b2h_atn = 0; sms_atn = 0; sms_clr_req = 1; tick(); chk("R9", 2'b11);
    endtask

    task automatic t_cold();
        rsp_ready = 1; cold_rst = 1; mask_wr_en = 1; mask_wr_data = 2'b01; tick();
        chk("R10", 2'b00);
    endtask

    task automatic t_order();
        mask_wr_en = 1; mask_wr_data = 2'b01; rsp_ready = 1; tick();
        chk("R11", 2'b11);
        mask_wr_en = 1; mask_wr_data = 2'b00; rsp_ready = 1; tick();
        chk("R11", 2'b00);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_same_en();
        t_ack();
        t_disable();
        t_rsp();
        t_sms_set();
        t_sms_clr();
        t_cold();
        t_order();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule